// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control brain of one thread's register-rename stage in an out-of-order core. It does no register mapping. Each cycle it looks at the group of instructions offered by decode, at its own skid buffer, and at the room left in the three back-end structures: reorder buffer, issue queue and load/store queue. From these it decides how many instructions rename may process. It also says how many are pushed into or popped from the skid buffer, whether decode must hold, and which structure caused a full stall.

Instructions already sent to the back end but not yet counted in its occupancy are given as an in-flight count. That count is taken off every free-entry figure, with a floor of zero. A serializing (barrier) instruction only goes through once the reorder buffer reports empty and nothing is in flight, and it goes through alone. A squash request beats every other condition: it empties the skid buffer and walks a short squash sequence.

Every output is registered. The decision made from the inputs of one cycle shows on the outputs right after the next rising edge. The skid buffer's payload storage is outside this block. The block keeps the occupancy count and the barrier flag of each skid entry.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset, `stage_state` is idle (code 0), `ren_cnt`, `skid_push` and `skid_pop` are 0, `skid_flush` and `block_decode` are 0, and `full_src` is 3 (none).
- R2: When not stalled, `ren_cnt` is the smallest of `WIDTH`, the number of candidate instructions and each structure's adjusted free count. Candidates are the skid head entries when the skid is not empty; otherwise they are the decode group, whose valid bits are contiguous from bit 0.
- R3: Each adjusted free count is the structure's free count minus `inflight`, held at 0 when the difference would be negative.
- R4: `full_src` reports the first structure whose adjusted free count is 0, in the order reorder buffer (0), issue queue (1), load/store queue (2). It reports 3 when none is zero. Any zero count moves the state to blocked (code 4), with `ren_cnt` 0 and every valid decode instruction pushed.
- R5: A stall request from the execute stage or from the commit stage, either one alone, moves the state to blocked with `ren_cnt` 0.
- R6: From blocked, the first unstalled cycle always goes to unblocking (code 5). Running (code 1) is entered only when the skid buffer will be empty. While the skid holds entries, renaming pops from it and all new decode instructions are pushed behind.
- R7: Decode instructions that are offered but not renamed are pushed into the skid buffer (`skid_push` = valid count minus `ren_cnt` when the skid was empty).
- R8: A barrier at the head of the candidates waits in the serialize-stall state (code 6) with `ren_cnt` 0 until `rob_empty` is 1 and `inflight` is 0. It is then renamed alone (`ren_cnt` = 1).
- R9: When a barrier (`dec_serial` bit set) sits behind other candidates, only the instructions ahead of it are renamed that cycle.
- R10: `squash_req` overrides stalls and barriers. It pulses `skid_flush`, empties the skid, and enters start-squash (code 2), then squashing (code 3) for one cycle, then idle. No instruction is renamed, pushed or popped in those cycles, and decode input is dropped.
- R11: `block_decode` is 1 when the next state is blocked, or when the skid buffer's free room after this cycle is less than `WIDTH`.
- R12: With an empty skid buffer, no valid decode instruction and no stall, the state becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | WIDTH | Valid bits of the decode group, contiguous from bit 0 |
| dec_serial | input | WIDTH | Barrier flag per decode slot |
| rob_free | input | FREE_W | Free reorder-buffer entries |
| iq_free | input | FREE_W | Free issue-queue entries |
| lsq_free | input | FREE_W | Free load/store-queue entries |
| inflight | input | FREE_W | Instructions sent but not yet in back-end counts |
| rob_empty | input | 1 | Reorder buffer is empty |
| exe_stall | input | 1 | Stall request from the execute stage |
| cmt_stall | input | 1 | Stall request from the commit stage |
| squash_req | input | 1 | Squash this thread |
| ren_cnt | output | CW | Instructions renamed this cycle |
| skid_push | output | CW | Decode instructions written into the skid buffer |
| skid_pop | output | CW | Skid head entries consumed |
| skid_flush | output | 1 | Skid buffer emptied |
| block_decode | output | 1 | Decode must not send a group |
| full_src | output | 2 | Structure causing a full stall, 3 for none |
| stage_state | output | 3 | Controller state code |

## Verification
The embedded assertions check, on every cycle, that the skid occupancy never exceeds its depth and never pops more than it holds. They also check that a flush leaves it empty and that the squash sequence advances one step per cycle. Further cycle checks cover that blocked only exits through unblocking or a squash, that running always coincides with an empty skid, that low skid room always raises `block_decode`, and that either stall request leads to blocked. The exact rename count under each limit, the full-source priority, the effect of the in-flight subtraction, barrier placement and release, and the drain order after a block depend on specific input patterns. Those are shown only by the bench's vector table and directed sequences.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN      = 3'd1,
    ST_SQ_START = 3'd2,
    ST_SQ_DRAIN = 3'd3,
    ST_BLOCKED  = 3'd4,
    ST_UNBLOCK  = 3'd5,
    ST_SER_WAIT = 3'd6
  } rsc_state_e;

  // Full-stall source, priority order is the encoding order
  typedef enum logic [1:0] {
    SRC_ROB  = 2'd0,
    SRC_IQ   = 2'd1,
    SRC_LSQ  = 2'd2,
    SRC_NONE = 2'd3
  } rsc_src_e;

endpackage

// File: rtl/rsc_credit.sv
module rsc_credit
  import rsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 6,
  parameter int CW     = $clog2(WIDTH + 1)
) (
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic [FREE_W-1:0] inflight,
  output logic [CW-1:0]     credit,
  output logic              full,
  output rsc_src_e          src
);
  localparam int NSTRUCT = 3;

  logic [FREE_W-1:0] raw [NSTRUCT];
  logic [FREE_W-1:0] adj [NSTRUCT];
  logic [FREE_W-1:0] low;

  assign raw[0] = rob_free;
  assign raw[1] = iq_free;
  assign raw[2] = lsq_free;

  // R3: subtract instructions not yet visible in back-end counts
  for (genvar g = 0; g < NSTRUCT; g++) begin : g_adj
    assign adj[g] = (raw[g] > inflight) ? (raw[g] - inflight) : '0;
  end

  always_comb begin
    low = adj[0];
    for (int i = 1; i < NSTRUCT; i++) begin
      if (adj[i] < low) low = adj[i];
    end
    credit = (low > FREE_W'(WIDTH)) ? CW'(WIDTH) : CW'(low);
  end

  always_comb begin
    full = 1'b1;
    if (adj[0] == '0)      src = SRC_ROB;
    else if (adj[1] == '0) src = SRC_IQ;
    else if (adj[2] == '0) src = SRC_LSQ;
    else begin
      src  = SRC_NONE;
      full = 1'b0;
    end
  end

endmodule

// File: rtl/rsc_skid_track.sv
module rsc_skid_track #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 12,
  parameter int CW    = $clog2(WIDTH + 1),
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    push,
  input  logic [CW-1:0]    pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] push_flags,
  output logic [OW-1:0]    occ,
  output logic [WIDTH-1:0] head_flags
);
  logic [DEPTH-1:0] flg, flg_nx;
  logic [OW-1:0]    base, occ_nx;

  always_comb begin
    base   = occ - OW'(pop);
    occ_nx = base + OW'(push);
    flg_nx = flg >> pop;
    for (int j = 0; j < DEPTH; j++) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (CW'(i) < push && (int'(base) + i) == j) flg_nx[j] = push_flags[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ <= '0;
      flg <= '0;
    end else begin
      occ <= occ_nx;
      flg <= flg_nx;
    end
  end

  assign head_flags = flg[WIDTH-1:0];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  assert_pop_bound_R6: assert property (@(posedge clk) disable iff (rst)
    OW'(pop) <= occ);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> occ == '0);

endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
  import rsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int FREE_W = 6,
  parameter int DEPTH  = 12,
  parameter int CW     = $clog2(WIDTH + 1),
  parameter int OW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  dec_valid,
  input  logic [WIDTH-1:0]  dec_serial,
  input  logic [FREE_W-1:0] inflight,
  input  logic              rob_empty,
  input  logic              exe_stall,
  input  logic              cmt_stall,
  input  logic              squash_req,
  input  logic [CW-1:0]     credit,
  input  logic              full,
  input  rsc_src_e          src,
  input  logic [OW-1:0]     occ,
  input  logic [WIDTH-1:0]  head_flags,
  output logic [CW-1:0]     push,
  output logic [CW-1:0]     pop,
  output logic              flush,
  output logic [WIDTH-1:0]  push_flags,
  output logic [CW-1:0]     ren_q,
  output logic [CW-1:0]     push_q,
  output logic [CW-1:0]     pop_q,
  output logic              flush_q,
  output logic              blk_q,
  output rsc_src_e          src_q,
  output rsc_state_e        state_q
);
  rsc_state_e       nxt;
  logic [CW-1:0]    dec_cnt, cand_cnt, lim, n, k;
  logic [WIDTH-1:0] cand_flags;
  logic             from_skid, has_ser, drained, stalled, ser_wait, blk_nx;
  logic [OW-1:0]    occ_nx;

  // Candidate group: skid head when it holds entries, else decode group
  always_comb begin
    dec_cnt = '0;
    for (int i = 0; i < WIDTH; i++) dec_cnt = dec_cnt + CW'(dec_valid[i]);
    from_skid  = (occ != '0);
    cand_cnt   = from_skid ? ((occ > OW'(WIDTH)) ? CW'(WIDTH) : CW'(occ)) : dec_cnt;
    cand_flags = from_skid ? head_flags : dec_serial;
    has_ser = 1'b0;
    k       = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!has_ser && CW'(i) < cand_cnt && cand_flags[i]) begin
        has_ser = 1'b1;
        k       = CW'(i);
      end
    end
    lim      = (cand_cnt < credit) ? cand_cnt : credit;
    drained  = rob_empty && (inflight == '0);
    stalled  = exe_stall || cmt_stall || full;
    ser_wait = has_ser && (k == '0) && !drained;
  end

  always_comb begin
    nxt   = state_q;
    n     = '0;
    push  = '0;
    pop   = '0;
    flush = 1'b0;
    if (squash_req) begin
      flush = 1'b1;
      nxt   = ST_SQ_START;
    end else if (state_q == ST_SQ_START) begin
      nxt = ST_SQ_DRAIN;
    end else if (state_q == ST_SQ_DRAIN) begin
      nxt = ST_IDLE;
    end else begin
      if (!stalled) begin
        if (has_ser && k == '0) n = drained ? CW'(1) : '0;
        else if (has_ser && k < lim) n = k;
        else n = lim;
      end
      push = from_skid ? dec_cnt : (dec_cnt - n);
      pop  = from_skid ? n : '0;
    end
    occ_nx = flush ? '0 : (occ - OW'(pop) + OW'(push));
    if (!squash_req && !(state_q inside {ST_SQ_START, ST_SQ_DRAIN})) begin
      if (stalled)                  nxt = ST_BLOCKED;
      else if (state_q == ST_BLOCKED) nxt = ST_UNBLOCK;
      else if (ser_wait)            nxt = ST_SER_WAIT;
      else if (occ_nx != '0)        nxt = ST_UNBLOCK;
      else if (cand_cnt == '0)      nxt = ST_IDLE;
      else                          nxt = ST_RUN;
    end
    push_flags = from_skid ? dec_serial : (dec_serial >> n);
    blk_nx = (nxt == ST_BLOCKED) || ((DEPTH - int'(occ_nx)) < WIDTH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ren_q   <= '0;
      push_q  <= '0;
      pop_q   <= '0;
      flush_q <= 1'b0;
      blk_q   <= 1'b0;
      src_q   <= SRC_NONE;
    end else begin
      state_q <= nxt;
      ren_q   <= n;
      push_q  <= push;
      pop_q   <= pop;
      flush_q <= flush;
      blk_q   <= blk_nx;
      src_q   <= src;
    end
  end

  assert_squash_entry_R10: assert property (@(posedge clk) disable iff (rst)
    squash_req |=> state_q == ST_SQ_START);

  assert_squash_step_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SQ_START && !squash_req) |=> state_q == ST_SQ_DRAIN);

  assert_block_exit_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_BLOCKED |=> state_q inside {ST_BLOCKED, ST_UNBLOCK, ST_SQ_START});

  assert_run_empty_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_RUN |-> occ == '0);

  assert_room_block_R11: assert property (@(posedge clk) disable iff (rst)
    ((DEPTH - int'(occ)) < WIDTH) |-> blk_q);

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    ((exe_stall || cmt_stall) && !squash_req && !(state_q inside {ST_SQ_START, ST_SQ_DRAIN}))
      |=> (state_q == ST_BLOCKED && ren_q == '0));

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
  import rsc_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int FREE_W     = 6,
  parameter int SKID_DEPTH = 12,
  parameter int CW         = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  dec_valid,
  input  logic [WIDTH-1:0]  dec_serial,
  input  logic [FREE_W-1:0] rob_free,
  input  logic [FREE_W-1:0] iq_free,
  input  logic [FREE_W-1:0] lsq_free,
  input  logic [FREE_W-1:0] inflight,
  input  logic              rob_empty,
  input  logic              exe_stall,
  input  logic              cmt_stall,
  input  logic              squash_req,
  output logic [CW-1:0]     ren_cnt,
  output logic [CW-1:0]     skid_push,
  output logic [CW-1:0]     skid_pop,
  output logic              skid_flush,
  output logic              block_decode,
  output logic [1:0]        full_src,
  output logic [2:0]        stage_state
);
  localparam int OW = $clog2(SKID_DEPTH + 1);

  logic [CW-1:0]    credit, push, pop;
  logic             full, flush;
  rsc_src_e         src, src_q;
  rsc_state_e       state_q;
  logic [OW-1:0]    occ;
  logic [WIDTH-1:0] head_flags, push_flags;

  rsc_credit #(.WIDTH(WIDTH), .FREE_W(FREE_W), .CW(CW)) u_credit (
    .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free),
    .inflight(inflight), .credit(credit), .full(full), .src(src)
  );

  rsc_skid_track #(.WIDTH(WIDTH), .DEPTH(SKID_DEPTH), .CW(CW), .OW(OW)) u_skid (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
    .push_flags(push_flags), .occ(occ), .head_flags(head_flags)
  );

  rsc_fsm #(.WIDTH(WIDTH), .FREE_W(FREE_W), .DEPTH(SKID_DEPTH), .CW(CW), .OW(OW)) u_fsm (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_serial(dec_serial),
    .inflight(inflight), .rob_empty(rob_empty), .exe_stall(exe_stall),
    .cmt_stall(cmt_stall), .squash_req(squash_req), .credit(credit),
    .full(full), .src(src), .occ(occ), .head_flags(head_flags),
    .push(push), .pop(pop), .flush(flush), .push_flags(push_flags),
    .ren_q(ren_cnt), .push_q(skid_push), .pop_q(skid_pop),
    .flush_q(skid_flush), .blk_q(block_decode), .src_q(src_q), .state_q(state_q)
  );

  assign full_src    = src_q;
  assign stage_state = state_q;

endmodule

// File: tb/tb_rename_stall_ctrl.sv
`timescale 1ns/1ps
module tb_rename_stall_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] dec_valid = '0, dec_serial = '0;
  logic [5:0] rob_free = 6'd20, iq_free = 6'd20, lsq_free = 6'd20, inflight = '0;
  logic rob_empty = 1'b1, exe_stall = 1'b0, cmt_stall = 1'b0, squash_req = 1'b0;
  logic [2:0] ren_cnt, skid_push, skid_pop;
  logic skid_flush, block_decode;
  logic [1:0] full_src;
  logic [2:0] stage_state;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rename_stall_ctrl dut (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_serial(dec_serial),
    .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free),
    .inflight(inflight), .rob_empty(rob_empty), .exe_stall(exe_stall),
    .cmt_stall(cmt_stall), .squash_req(squash_req), .ren_cnt(ren_cnt),
    .skid_push(skid_push), .skid_pop(skid_pop), .skid_flush(skid_flush),
    .block_decode(block_decode), .full_src(full_src), .stage_state(stage_state)
  );

  typedef struct packed {
    logic [3:0] v; logic [3:0] s;
    logic [5:0] rob; logic [5:0] iq; logic [5:0] lsq; logic [5:0] inf;
    logic re;
    logic [2:0] e_ren; logic [2:0] e_push; logic [1:0] e_src;
    logic [2:0] e_st; logic e_blk;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TAB [NV] = '{
    '{4'hF, 4'h0, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd4, 3'd0, 2'd3, 3'd1, 1'b0}, // R2 full width
    '{4'h3, 4'h0, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd2, 3'd0, 2'd3, 3'd1, 1'b0}, // R2 valid limit
    '{4'hF, 4'h0, 6'd2,  6'd20, 6'd20, 6'd0, 1'b1, 3'd2, 3'd2, 2'd3, 3'd5, 1'b0}, // R2 R7 rob limit
    '{4'hF, 4'h0, 6'd20, 6'd3,  6'd20, 6'd1, 1'b1, 3'd2, 3'd2, 2'd3, 3'd5, 1'b0}, // R3 iq minus inflight
    '{4'hF, 4'h0, 6'd0,  6'd0,  6'd20, 6'd0, 1'b1, 3'd0, 3'd4, 2'd0, 3'd4, 1'b1}, // R4 rob beats iq
    '{4'hF, 4'h0, 6'd20, 6'd0,  6'd0,  6'd0, 1'b1, 3'd0, 3'd4, 2'd1, 3'd4, 1'b1}, // R4 iq beats lsq
    '{4'hF, 4'h0, 6'd20, 6'd20, 6'd0,  6'd0, 1'b1, 3'd0, 3'd4, 2'd2, 3'd4, 1'b1}, // R4 lsq
    '{4'hF, 4'h0, 6'd3,  6'd20, 6'd20, 6'd5, 1'b1, 3'd0, 3'd4, 2'd0, 3'd4, 1'b1}, // R3 saturate to 0
    '{4'h0, 4'h0, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd0, 3'd0, 2'd3, 3'd0, 1'b0}, // R12 idle
    '{4'hF, 4'h4, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd2, 3'd2, 2'd3, 3'd5, 1'b0}, // R9 barrier slot 2
    '{4'hF, 4'h1, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd1, 3'd3, 2'd3, 3'd5, 1'b0}, // R8 drained, alone
    '{4'hF, 4'h1, 6'd20, 6'd20, 6'd20, 6'd0, 1'b0, 3'd0, 3'd4, 2'd3, 3'd6, 1'b0}, // R8 rob not empty
    '{4'h1, 4'h1, 6'd20, 6'd20, 6'd20, 6'd0, 1'b1, 3'd1, 3'd0, 2'd3, 3'd1, 1'b0}, // R8 single barrier
    '{4'hF, 4'h1, 6'd20, 6'd20, 6'd20, 6'd2, 1'b1, 3'd0, 3'd4, 2'd3, 3'd6, 1'b0}, // R8 R3 inflight holds
    '{4'hF, 4'h0, 6'd20, 6'd20, 6'd1,  6'd0, 1'b1, 3'd1, 3'd3, 2'd3, 3'd5, 1'b0}  // R2 lsq limit
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    dec_valid = '0; dec_serial = '0;
    rob_free = 6'd20; iq_free = 6'd20; lsq_free = 6'd20; inflight = '0;
    rob_empty = 1'b1; exe_stall = 1'b0; cmt_stall = 1'b0; squash_req = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "state", stage_state, 0);
    chk("R1", "ren", ren_cnt, 0);
    chk("R1", "push", skid_push, 0);
    chk("R1", "pop", skid_pop, 0);
    chk("R1", "flush", skid_flush, 0);
    chk("R1", "block", block_decode, 0);
    chk("R1", "src", full_src, 3);

    for (int r = 0; r < NV; r++) begin
      do_reset();
      dec_valid = TAB[r].v; dec_serial = TAB[r].s;
      rob_free = TAB[r].rob; iq_free = TAB[r].iq; lsq_free = TAB[r].lsq;
      inflight = TAB[r].inf; rob_empty = TAB[r].re;
      step();
      chk("R2", $sformatf("row%0d ren", r), ren_cnt, TAB[r].e_ren);
      chk("R7", $sformatf("row%0d push", r), skid_push, TAB[r].e_push);
      chk("R4", $sformatf("row%0d src", r), full_src, TAB[r].e_src);
      chk("R6", $sformatf("row%0d state", r), stage_state, TAB[r].e_st);
      chk("R11", $sformatf("row%0d block", r), block_decode, TAB[r].e_blk);
    end

    // R5 / R6: execute stall, then drain through unblocking
    do_reset();
    dec_valid = 4'hF; exe_stall = 1'b1; step();
    chk("R5", "exe stall state", stage_state, 4);
    chk("R5", "exe stall ren", ren_cnt, 0);
    chk("R5", "exe stall push", skid_push, 4);
    chk("R11", "blocked block", block_decode, 1);
    dec_valid = 4'h0; exe_stall = 1'b0; step();
    chk("R6", "exit state", stage_state, 5);
    chk("R6", "exit pop", skid_pop, 4);
    chk("R6", "exit ren", ren_cnt, 4);
    dec_valid = 4'h3; step();
    chk("R6", "run state", stage_state, 1);
    chk("R6", "run ren", ren_cnt, 2);
    chk("R6", "run pop", skid_pop, 0);
    dec_valid = 4'h0; cmt_stall = 1'b1; step();
    chk("R5", "commit stall state", stage_state, 4);
    cmt_stall = 1'b0; step();
    chk("R6", "commit exit state", stage_state, 5);

    // R11: skid room controls block_decode
    do_reset();
    dec_valid = 4'hF; exe_stall = 1'b1;
    step(); step(); step();
    chk("R11", "full skid block", block_decode, 1);
    dec_valid = 4'h0; exe_stall = 1'b0; rob_free = 6'd2; step();
    chk("R11", "pop2 pop", skid_pop, 2);
    chk("R11", "room 2 block", block_decode, 1);
    rob_free = 6'd20; step();
    chk("R11", "room 6 block", block_decode, 0);
    chk("R6", "draining state", stage_state, 5);
    step(); step();
    chk("R6", "drained run", stage_state, 1);
    chk("R6", "drained ren", ren_cnt, 2);

    // R10: squash beats stall, flushes skid
    do_reset();
    dec_valid = 4'hF; exe_stall = 1'b1; step();
    squash_req = 1'b1; step();
    chk("R10", "start state", stage_state, 2);
    chk("R10", "flush", skid_flush, 1);
    chk("R10", "start push", skid_push, 0);
    squash_req = 1'b0; exe_stall = 1'b0; step();
    chk("R10", "squashing state", stage_state, 3);
    chk("R10", "squashing ren", ren_cnt, 0);
    chk("R10", "squashing push", skid_push, 0);
    dec_valid = 4'h0; step();
    chk("R10", "idle after", stage_state, 0);
    dec_valid = 4'h3; step();
    chk("R10", "skid empty ren", ren_cnt, 2);
    chk("R10", "skid empty pop", skid_pop, 0);
    chk("R10", "skid empty state", stage_state, 1);

    // R8: barrier held in skid until drained
    do_reset();
    dec_valid = 4'hF; dec_serial = 4'h1; rob_empty = 1'b0; step();
    chk("R8", "wait state", stage_state, 6);
    dec_valid = 4'h0; dec_serial = 4'h0; step();
    chk("R8", "still waiting", stage_state, 6);
    chk("R8", "waiting ren", ren_cnt, 0);
    rob_empty = 1'b1; step();
    chk("R8", "release ren", ren_cnt, 1);
    chk("R8", "release pop", skid_pop, 1);
    chk("R8", "release state", stage_state, 5);
    step();
    chk("R8", "rest ren", ren_cnt, 3);
    chk("R8", "rest state", stage_state, 1);

    finish_run();
  end
endmodule